// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the purely combinational front of a small 32-bit processor whose instructions take 1, 2, 5 or 6 bytes. The caller presents the program counter and the six bytes stored from that address upward. The block splits the leading byte into an opcode and a function code. From the opcode it decides whether a register-specifier byte follows and whether a 4-byte constant is present, and it pulls both out. It also reports the instruction length and the fall-through address.

The constant starts one byte later when a register byte comes before it. Fields that the instruction does not carry are driven to fixed values, so downstream logic never sees leftover bytes from the next instruction. Opcodes outside the defined set raise no action beyond clearing the valid flag. Selecting the next program counter and acting on invalid instructions are left to the logic that uses these outputs.

Top module: `vlfetch_decoder`

## Requirements
- R1: The opcode output equals bits [7:4] of the first byte and the function output equals bits [3:0] of the first byte, for every opcode.
- R2: The valid output is 1 exactly for opcodes 0x0 to 0xB and 0 for 0xC to 0xF.
- R3: A register byte is present (has_regs_o=1) only for opcodes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB. Then ra_o is bits [7:4] and rb_o is bits [3:0] of the second byte, passed through unchanged, including the value 8.
- R4: When no register byte is present, ra_o and rb_o both equal 8, the no-register ID.
- R5: For opcodes 0x3, 0x4 and 0x5, the constant is the bytes at PC+2 to PC+5, little-endian, with the byte at PC+2 least significant.
- R6: For opcodes 0x7 and 0x8, the constant is the bytes at PC+1 to PC+4, little-endian, with the byte at PC+1 least significant.
- R7: A constant is present (has_imm_o=1) only for opcodes 0x3, 0x4, 0x5, 0x7 and 0x8. Otherwise imm_o is zero.
- R8: The length is 1 for opcodes 0x0, 0x1, 0x9 and any invalid opcode. It is 2 for 0x2, 0x6, 0xA and 0xB, 5 for 0x7 and 0x8, and 6 for 0x3, 0x4 and 0x5.
- R9: next_pc_o equals pc_i plus the length, modulo 2^32, so it wraps past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the first instruction byte |
| ibytes_i | input | 48 | Six bytes from pc_i upward; byte k at bits [8k+7:8k] |
| op_o | output | 4 | Opcode |
| fn_o | output | 4 | Function code |
| ra_o | output | 4 | First register specifier, or 8 |
| rb_o | output | 4 | Second register specifier, or 8 |
| imm_o | output | 32 | Constant word, or zero |
| has_regs_o | output | 1 | Register byte present |
| has_imm_o | output | 1 | Constant word present |
| valid_o | output | 1 | Opcode is defined |
| len_o | output | 3 | Instruction length in bytes |
| next_pc_o | output | 32 | Fall-through address |

## Verification
The hardest case to reach is an instruction whose fields straddle the top of the address space, where the sum of address and length must wrap. The stimulus places long and short instructions a few bytes below 2^32 and checks the wrapped result. Each byte position is also given a distinct value, so a constant taken from the wrong offset or in the wrong byte order cannot match by chance. Short instructions are sent with non-zero trailing bytes to show that unused bytes never leak into the outputs.

// File: rtl/fdec_pkg.sv
`timescale 1ns/1ps
package fdec_pkg;

  localparam int BYTE_W   = 8;
  localparam int NIB_W    = 4;
  localparam int LEN_W    = 3;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_HALT  = 4'h1,
    OP_RRMOV = 4'h2,
    OP_IRMOV = 4'h3,
    OP_RMMOV = 4'h4,
    OP_MRMOV = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opc_e;

  // Length from the optional-field flags: 1 base byte, +1 register byte, +4 constant bytes.
  function automatic logic [LEN_W-1:0] f_len(input logic regs, input logic imm);
    logic [LEN_W-1:0] n;
    n = 3'd1;
    if (regs) n = n + 3'd1;
    if (imm)  n = n + 3'd4;
    return n;
  endfunction

  // Fall-through address, modulo the address width.
  function automatic logic [31:0] f_advance(input logic [31:0] pc, input logic [LEN_W-1:0] n);
    return pc + {29'd0, n};
  endfunction

endpackage

// File: rtl/fdec_classify.sv
`timescale 1ns/1ps
module fdec_classify
  import fdec_pkg::*;
(
  input  logic [NIB_W-1:0] op_i,
  output logic             regs_o,
  output logic             imm_o,
  output logic             valid_o
);

  always_comb begin
    regs_o  = 1'b0;
    imm_o   = 1'b0;
    valid_o = 1'b1;
    case (op_i)
      OP_NOP, OP_HALT, OP_RET: ;
      OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: regs_o = 1'b1;
      OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
        regs_o = 1'b1;
        imm_o  = 1'b1;
      end
      OP_JUMP, OP_CALL: imm_o = 1'b1;
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/fdec_align.sv
`timescale 1ns/1ps
module fdec_align
  import fdec_pkg::*;
#(
  parameter int              WORD_BYTES = 4,
  parameter logic [NIB_W-1:0] NO_REG    = 4'h8,
  localparam int             TAIL_W     = (WORD_BYTES + 1) * BYTE_W,
  localparam int             WORD_W     = WORD_BYTES * BYTE_W
)(
  input  logic [TAIL_W-1:0] tail_i,   // bytes 1 .. WORD_BYTES+1
  input  logic              regs_i,
  input  logic              imm_i,
  output logic [NIB_W-1:0]  ra_o,
  output logic [NIB_W-1:0]  rb_o,
  output logic [WORD_W-1:0] imm_o
);

  logic [BYTE_W-1:0] regbyte;
  logic [WORD_W-1:0] word_at1;
  logic [WORD_W-1:0] word_at2;

  assign regbyte = tail_i[BYTE_W-1:0];

  // Little-endian gather: lane k of the constant comes from tail byte k (or k+1 after a register byte).
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign word_at1[k*BYTE_W +: BYTE_W] = tail_i[k*BYTE_W +: BYTE_W];
    assign word_at2[k*BYTE_W +: BYTE_W] = tail_i[(k+1)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    ra_o = regs_i ? regbyte[BYTE_W-1:NIB_W] : NO_REG;
    rb_o = regs_i ? regbyte[NIB_W-1:0]      : NO_REG;
    if (!imm_i)      imm_o = '0;
    else if (regs_i) imm_o = word_at2;
    else             imm_o = word_at1;
  end

endmodule

// File: rtl/fdec_pcinc.sv
`timescale 1ns/1ps
module fdec_pcinc
  import fdec_pkg::*;
(
  input  logic [31:0]      pc_i,
  input  logic             regs_i,
  input  logic             imm_i,
  output logic [LEN_W-1:0] len_o,
  output logic [31:0]      next_o
);

  assign len_o  = f_len(regs_i, imm_i);
  assign next_o = f_advance(pc_i, len_o);

endmodule

// File: rtl/vlfetch_decoder.sv
`timescale 1ns/1ps
module vlfetch_decoder
  import fdec_pkg::*;
(
  input  logic [31:0] pc_i,
  input  logic [47:0] ibytes_i,
  output logic [3:0]  op_o,
  output logic [3:0]  fn_o,
  output logic [3:0]  ra_o,
  output logic [3:0]  rb_o,
  output logic [31:0] imm_o,
  output logic        has_regs_o,
  output logic        has_imm_o,
  output logic        valid_o,
  output logic [2:0]  len_o,
  output logic [31:0] next_pc_o
);

  logic [BYTE_W-1:0] head_byte;
  logic              need_regs;
  logic              need_imm;

  assign head_byte = ibytes_i[BYTE_W-1:0];
  assign op_o      = head_byte[BYTE_W-1:NIB_W];
  assign fn_o      = head_byte[NIB_W-1:0];

  fdec_classify u_cls (
    .op_i    (op_o),
    .regs_o  (need_regs),
    .imm_o   (need_imm),
    .valid_o (valid_o)
  );

  fdec_align #(.WORD_BYTES(4), .NO_REG(4'h8)) u_aln (
    .tail_i (ibytes_i[47:8]),
    .regs_i (need_regs),
    .imm_i  (need_imm),
    .ra_o   (ra_o),
    .rb_o   (rb_o),
    .imm_o  (imm_o)
  );

  fdec_pcinc u_pc (
    .pc_i   (pc_i),
    .regs_i (need_regs),
    .imm_i  (need_imm),
    .len_o  (len_o),
    .next_o (next_pc_o)
  );

  assign has_regs_o = need_regs;
  assign has_imm_o  = need_imm;

endmodule

// File: rtl/fdec_checker.sv
`timescale 1ns/1ps
module fdec_checker (
  input logic [31:0] pc_i,
  input logic [47:0] ibytes_i,
  input logic [3:0]  op_o,
  input logic [3:0]  ra_o,
  input logic [3:0]  rb_o,
  input logic [31:0] imm_o,
  input logic        has_regs_o,
  input logic        has_imm_o,
  input logic        valid_o,
  input logic [2:0]  len_o,
  input logic [31:0] next_pc_o
);

  always_comb begin
    if (!$isunknown({pc_i, ibytes_i})) begin
      // R2
      valid_ops_chk: assert (valid_o == (op_o <= 4'hB));
      // R3
      reg_fields_chk: assert (!has_regs_o || (ra_o == ibytes_i[15:12] && rb_o == ibytes_i[11:8]));
      // R4
      no_reg_chk: assert (has_regs_o || (ra_o == 4'h8 && rb_o == 4'h8));
      // R6
      short_imm_chk: assert (!(has_imm_o && !has_regs_o) || imm_o == ibytes_i[39:8]);
      // R7
      imm_zero_chk: assert (has_imm_o || imm_o == 32'd0);
      // R8
      len_set_chk: assert (len_o == 3'd1 || len_o == 3'd2 || len_o == 3'd5 || len_o == 3'd6);
      // R9
      next_pc_chk: assert (next_pc_o - pc_i == {29'd0, len_o});
    end
  end

endmodule

bind vlfetch_decoder fdec_checker u_fdec_chk (
  .pc_i       (pc_i),
  .ibytes_i   (ibytes_i),
  .op_o       (op_o),
  .ra_o       (ra_o),
  .rb_o       (rb_o),
  .imm_o      (imm_o),
  .has_regs_o (has_regs_o),
  .has_imm_o  (has_imm_o),
  .valid_o    (valid_o),
  .len_o      (len_o),
  .next_pc_o  (next_pc_o)
);

// File: tb/sim_vlfetch_decoder.sv
`timescale 1ns/1ps
module sim_vlfetch_decoder;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] pc_i;
  logic [47:0] ibytes_i;
  logic [3:0]  op_o, fn_o, ra_o, rb_o;
  logic [31:0] imm_o, next_pc_o;
  logic        has_regs_o, has_imm_o, valid_o;
  logic [2:0]  len_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vlfetch_decoder u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent expectation tables taken from the requirement text.
  function automatic bit e_regs(input logic [3:0] o);
    return (o inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB});
  endfunction
  function automatic bit e_imm(input logic [3:0] o);
    return (o inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8});
  endfunction
  function automatic int e_len(input logic [3:0] o);
    case (o)
      4'h2, 4'h6, 4'hA, 4'hB: return 2;
      4'h7, 4'h8:             return 5;
      4'h3, 4'h4, 4'h5:       return 6;
      default:                return 1;
    endcase
  endfunction

  task automatic apply(input logic [31:0] pc, input logic [7:0] b0, b1, b2, b3, b4, b5);
    @(negedge clk);
    pc_i     = pc;
    ibytes_i = {b5, b4, b3, b2, b1, b0};
    #1;
  endtask

  // Full comparison of every output for one instruction image.
  task automatic check_all(input logic [31:0] pc, input logic [7:0] b0, b1, b2, b3, b4, b5);
    logic [3:0]  o;
    logic [31:0] ei;
    apply(pc, b0, b1, b2, b3, b4, b5);
    o = b0[7:4];
    chk("R1", "opcode", {28'd0, op_o}, {28'd0, o});
    chk("R1", "function", {28'd0, fn_o}, {28'd0, b0[3:0]});
    chk("R2", "valid", {31'd0, valid_o}, {31'd0, (o < 4'd12)});
    chk("R3", "has_regs", {31'd0, has_regs_o}, {31'd0, e_regs(o)});
    chk("R7", "has_imm", {31'd0, has_imm_o}, {31'd0, e_imm(o)});
    if (e_regs(o)) begin
      chk("R3", "ra", {28'd0, ra_o}, {28'd0, b1[7:4]});
      chk("R3", "rb", {28'd0, rb_o}, {28'd0, b1[3:0]});
    end else begin
      chk("R4", "ra", {28'd0, ra_o}, 32'd8);
      chk("R4", "rb", {28'd0, rb_o}, 32'd8);
    end
    if (!e_imm(o))      ei = 32'd0;
    else if (e_regs(o)) ei = {b5, b4, b3, b2};
    else                ei = {b4, b3, b2, b1};
    chk(e_imm(o) ? (e_regs(o) ? "R5" : "R6") : "R7", "imm", imm_o, ei);
    chk("R8", "len", {29'd0, len_o}, e_len(o));
    chk("R9", "next_pc", next_pc_o, pc + e_len(o));
  endtask

  task automatic t_idle;
    check_all(32'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] o = 4'(i);
      check_all(32'h0000_1000 + 32'(i * 16), {o, 4'(15 - i)}, 8'h3C, 8'h11, 8'h22, 8'h33, 8'h44);
    end
  endtask

  task automatic t_reg_forms;
    check_all(32'h100, 8'h30, 8'h85, 8'hEF, 8'hBE, 8'hAD, 8'hDE);  // R3 R5 rA=8 passes through
    check_all(32'h200, 8'hA0, 8'h48, 8'hFF, 8'hFF, 8'hFF, 8'hFF);  // R3 rB=8 for push
    check_all(32'h300, 8'hB0, 8'h08, 8'h77, 8'h77, 8'h77, 8'h77);
    check_all(32'h400, 8'h63, 8'h27, 8'h01, 8'h02, 8'h03, 8'h04);
    check_all(32'h500, 8'h40, 8'h13, 8'h78, 8'h56, 8'h34, 8'h12);  // R5
    check_all(32'h600, 8'h50, 8'h31, 8'hF7, 8'hFF, 8'hFF, 8'hFF);
  endtask

  task automatic t_short_imm;
    check_all(32'h700, 8'h73, 8'h0D, 8'hC0, 8'h00, 8'h00, 8'hEE);  // R6
    check_all(32'h800, 8'h80, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'h99);  // R6
  endtask

  task automatic t_no_leak;
    check_all(32'h900, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);  // R4 R7
    check_all(32'hA00, 8'h90, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A);  // R4 R7
    check_all(32'hB00, 8'hF0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A);  // R2 R8 invalid length 1
  endtask

  task automatic t_wrap;
    check_all(32'hFFFF_FFFC, 8'h30, 8'hF1, 8'h01, 8'h00, 8'h00, 8'h00);  // R9 -> 2
    check_all(32'hFFFF_FFFF, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);  // R9 -> 0
    check_all(32'hFFFF_FFFD, 8'h80, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00);  // R9 -> 2
    check_all(32'hFFFF_FFFE, 8'h20, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00);  // R9 -> 0
  endtask

  initial begin
    pc_i = '0;
    ibytes_i = '0;
    t_idle();
    t_sweep();
    t_reg_forms();
    t_short_imm();
    t_no_leak();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule